// File: doc/BRIEF.md
# Memory and Port Access Stage

This block is the fourth stage of a five-stage 8-bit core. Each cycle it takes one instruction slot from the execute stage (a valid bit, an operation code, an ALU-computed effective address, a store value, a destination register index and the ALU result). It carries out at most one access for that slot: a write or a read of its internal 256-byte data RAM, or a write or a read on an external port bus that has 256 output ports and 256 input ports. The data RAM and the port spaces are separate, so the same address value reaches different storage depending on the operation.

At the clock edge that ends the slot, the stage registers a destination index, a destination value and a write-enable bit for the write-back stage. The destination value is the loaded RAM byte, the sampled input port byte or the ALU result, depending on the operation. The RAM read is combinational, so load data is ready at the end-of-stage register in the same cycle. The port bus uses one strobe per direction, each high for exactly the cycle of its slot.

Top module: `memAccessStage`

## Requirements
- R1: While reset is asserted and just after it is released, wbWrEn, wbDestIdx and wbDestData are all zero.
- R2: A valid slot with operation code 0 (pass), or any code from 5 to 7, registers inAluResult into wbDestData and inDestIdx into wbDestIdx on the next edge.
- R3: A valid slot with operation code 1 (memory store) writes inStoreData into the RAM byte at inAddr at the clock edge, raises no port strobe, and leaves wbWrEn low after that edge.
- R4: A valid slot with operation code 2 (memory load) puts the RAM byte at inAddr into wbDestData on the next edge, with wbDestIdx equal to inDestIdx.
- R5: A valid slot with operation code 3 (port output) raises portWrStb in that same cycle, with portAddr equal to inAddr and portWrData equal to inStoreData, and leaves wbWrEn low after the edge.
- R6: A valid slot with operation code 4 (port input) raises portRdStb in that same cycle with portAddr equal to inAddr, and puts the portRdData value of that cycle into wbDestData on the next edge.
- R7: A slot with inValid low raises no strobe, changes no RAM byte and leaves wbWrEn low after the edge.
- R8: wbWrEn is never high when wbDestIdx is 0. A pass, load or port input aimed at index 0 registers wbWrEn low, and one aimed at any other index registers it high.
- R9: The RAM and the port address spaces are independent: a port output to address A leaves RAM byte A unchanged, and a RAM store raises no port strobe.
- R10: At most one port strobe is high at a time, and portAddr and portWrData are zero in cycles where the strobe that uses them is low.
- R11: A load that directly follows a store to the same address returns the newly stored byte, including at addresses 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Slot from execute holds a real instruction |
| inOp | input | 3 | Operation code (0 pass, 1 store, 2 load, 3 port out, 4 port in, 5-7 pass) |
| inAddr | input | 8 | Effective address from the ALU |
| inStoreData | input | 8 | Register value to store or send out |
| inDestIdx | input | 3 | Destination register index |
| inAluResult | input | 8 | ALU result for pass-through slots |
| portRdData | input | 8 | Input port data, sampled in the read-strobe cycle |
| portWrStb | output | 1 | Output port write strobe |
| portRdStb | output | 1 | Input port read strobe |
| portAddr | output | 8 | Port number |
| portWrData | output | 8 | Output port data |
| wbWrEn | output | 1 | Register-file write enable for write-back |
| wbDestIdx | output | 3 | Destination index for write-back |
| wbDestData | output | 8 | Destination data for write-back |

## Verification
The assertions take for granted that the input port device returns its byte in the same cycle as the read strobe and that every slot input is stable for the whole cycle. They also take for granted that no load asks for a RAM byte that was never stored, because the RAM has no reset. The bench drives every slot input just after the falling edge and holds it through the rising edge. It sets portRdData together with the slot, and it stores to each RAM address before the first load from that address.

// File: rtl/memStagePkg.sv
package memStagePkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PASS     = 3'd0,
    OP_STORE    = 3'd1,
    OP_LOAD     = 3'd2,
    OP_PORT_OUT = 3'd3,
    OP_PORT_IN  = 3'd4
  } stageOp_e;

  // Strobes from control to datapath; at most one access bit is set.
  typedef struct packed {
    logic memWr;
    logic memRd;
    logic portWr;
    logic portRd;
    logic destWr;
  } stageStrobes_t;
endpackage

// File: rtl/memStageCtrl.sv
module memStageCtrl
  import memStagePkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                inValid,
  input  logic [OP_W-1:0]     inOp,
  input  logic [IDX_W-1:0]    inDestIdx,
  output stageStrobes_t       strobes
);
  logic isStore, isLoad, isOut, isIn;

  always_comb begin
    isStore = inValid && (inOp == OP_STORE);
    isLoad  = inValid && (inOp == OP_LOAD);
    isOut   = inValid && (inOp == OP_PORT_OUT);
    isIn    = inValid && (inOp == OP_PORT_IN);

    strobes.memWr  = isStore;
    strobes.memRd  = isLoad;
    strobes.portWr = isOut;
    strobes.portRd = isIn;
    // Slots that produce a register result, minus the hard-wired zero register.
    strobes.destWr = inValid && !isStore && !isOut && (inDestIdx != '0);
  end
endmodule

// File: rtl/memStageDatapath.sv
module memStageDatapath
  import memStagePkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  stageStrobes_t       strobes,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   storeData,
  input  logic [IDX_W-1:0]    destIdx,
  input  logic [DATA_W-1:0]   aluResult,
  input  logic [DATA_W-1:0]   portRdData,
  output logic                portWrStb,
  output logic                portRdStb,
  output logic [ADDR_W-1:0]   portAddr,
  output logic [DATA_W-1:0]   portWrData,
  output logic                wbWrEn,
  output logic [IDX_W-1:0]    wbDestIdx,
  output logic [DATA_W-1:0]   wbDestData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];
  logic [DATA_W-1:0] loadData;
  logic [DATA_W-1:0] stageResult;

  always_ff @(posedge clk) begin
    if (strobes.memWr) ram[addr] <= storeData;
  end

  assign loadData = ram[addr];

  always_comb begin
    stageResult = aluResult;
    if (strobes.memRd)      stageResult = loadData;
    else if (strobes.portRd) stageResult = portRdData;
  end

  always_comb begin
    portWrStb  = strobes.portWr;
    portRdStb  = strobes.portRd;
    portAddr   = (strobes.portWr || strobes.portRd) ? addr : '0;
    portWrData = strobes.portWr ? storeData : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbWrEn     <= 1'b0;
      wbDestIdx  <= '0;
      wbDestData <= '0;
    end else begin
      wbWrEn     <= strobes.destWr;
      wbDestIdx  <= destIdx;
      wbDestData <= stageResult;
    end
  end
endmodule

// File: rtl/memAccessStage.sv
module memAccessStage
  import memStagePkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   inOp,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inStoreData,
  input  logic [IDX_W-1:0]  inDestIdx,
  input  logic [DATA_W-1:0] inAluResult,
  input  logic [DATA_W-1:0] portRdData,
  output logic              portWrStb,
  output logic              portRdStb,
  output logic [ADDR_W-1:0] portAddr,
  output logic [DATA_W-1:0] portWrData,
  output logic              wbWrEn,
  output logic [IDX_W-1:0]  wbDestIdx,
  output logic [DATA_W-1:0] wbDestData
);
  stageStrobes_t strobes;

  memStageCtrl #(.IDX_W(IDX_W)) uCtrl (
    .inValid   (inValid),
    .inOp      (inOp),
    .inDestIdx (inDestIdx),
    .strobes   (strobes)
  );

  memStageDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .addr       (inAddr),
    .storeData  (inStoreData),
    .destIdx    (inDestIdx),
    .aluResult  (inAluResult),
    .portRdData (portRdData),
    .portWrStb  (portWrStb),
    .portRdStb  (portRdStb),
    .portAddr   (portAddr),
    .portWrData (portWrData),
    .wbWrEn     (wbWrEn),
    .wbDestIdx  (wbDestIdx),
    .wbDestData (wbDestData)
  );
endmodule

// File: rtl/memAccessStageChecker.sv
module memAccessStageChecker
  import memStagePkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OP_W-1:0]   inOp,
  input logic [ADDR_W-1:0] inAddr,
  input logic [DATA_W-1:0] inStoreData,
  input logic [IDX_W-1:0]  inDestIdx,
  input logic [DATA_W-1:0] inAluResult,
  input logic [DATA_W-1:0] portRdData,
  input logic              portWrStb,
  input logic              portRdStb,
  input logic [ADDR_W-1:0] portAddr,
  input logic [DATA_W-1:0] portWrData,
  input logic              wbWrEn,
  input logic [IDX_W-1:0]  wbDestIdx,
  input logic [DATA_W-1:0] wbDestData
);
  assert_pass_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == OP_PASS) |=>
      (wbDestData == $past(inAluResult) && wbDestIdx == $past(inDestIdx)));

  assert_store_no_wr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == OP_STORE) |=> !wbWrEn);

  assert_port_out_bus_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == OP_PORT_OUT) |->
      (portWrStb && portAddr == inAddr && portWrData == inStoreData));

  assert_port_in_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == OP_PORT_IN) |=> (wbDestData == $past(portRdData)));

  assert_invalid_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (!portWrStb && !portRdStb));

  assert_invalid_no_wr_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !wbWrEn);

  assert_idx_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbWrEn |-> (wbDestIdx != '0));

  assert_store_no_port_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == OP_STORE) |-> (!portWrStb && !portRdStb));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({portWrStb, portRdStb}));

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rstN)
    !portWrStb |-> (portWrData == '0));
endmodule

bind memAccessStage memAccessStageChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inAddr(inAddr),
  .inStoreData(inStoreData), .inDestIdx(inDestIdx), .inAluResult(inAluResult),
  .portRdData(portRdData), .portWrStb(portWrStb), .portRdStb(portRdStb),
  .portAddr(portAddr), .portWrData(portWrData), .wbWrEn(wbWrEn),
  .wbDestIdx(wbDestIdx), .wbDestData(wbDestData)
);

// File: tb/tb_memAccessStage.sv
`timescale 1ns/1ps
module tb_memAccessStage;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [2:0] inOp = 3'd0;
  logic [7:0] inAddr = 8'd0;
  logic [7:0] inStoreData = 8'd0;
  logic [2:0] inDestIdx = 3'd0;
  logic [7:0] inAluResult = 8'd0;
  logic [7:0] portRdData = 8'd0;
  logic       portWrStb, portRdStb;
  logic [7:0] portAddr, portWrData;
  logic       wbWrEn;
  logic [2:0] wbDestIdx;
  logic [7:0] wbDestData;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  // Values seen during the slot (before the edge).
  logic       cWr, cRd;
  logic [7:0] cAddr, cData;

  always #2 clk = ~clk;

  memAccessStage dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inAddr(inAddr),
    .inStoreData(inStoreData), .inDestIdx(inDestIdx), .inAluResult(inAluResult),
    .portRdData(portRdData), .portWrStb(portWrStb), .portRdStb(portRdStb),
    .portAddr(portAddr), .portWrData(portWrData), .wbWrEn(wbWrEn),
    .wbDestIdx(wbDestIdx), .wbDestData(wbDestData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive one slot after the falling edge, capture the bus, then pass the edge.
  task automatic slot(input bit v, input logic [2:0] op, input logic [7:0] a,
                      input logic [7:0] st, input logic [2:0] idx,
                      input logic [7:0] alu, input logic [7:0] prd);
    @(negedge clk);
    inValid = v; inOp = op; inAddr = a; inStoreData = st;
    inDestIdx = idx; inAluResult = alu; portRdData = prd;
    #1;
    cWr = portWrStb; cRd = portRdStb; cAddr = portAddr; cData = portWrData;
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    check(wbWrEn == 1'b0, "R1", wbWrEn, 0);
    check(wbDestIdx == 3'd0, "R1", wbDestIdx, 0);
    check(wbDestData == 8'd0, "R1", wbDestData, 0);
  endtask

  task automatic testPass();
    slot(1, 3'd0, 8'h10, 8'h33, 3'd3, 8'h5A, 8'h00);
    check(wbDestData == 8'h5A, "R2", wbDestData, 8'h5A);
    check(wbDestIdx == 3'd3, "R2", wbDestIdx, 3);
    check(wbWrEn == 1'b1, "R8", wbWrEn, 1);
    check(!cWr && !cRd, "R10", {cWr, cRd}, 0);
    check(cAddr == 8'h00 && cData == 8'h00, "R10", {cAddr, cData}, 0);
    slot(1, 3'd6, 8'h00, 8'h00, 3'd7, 8'hC3, 8'h00);
    check(wbDestData == 8'hC3 && wbDestIdx == 3'd7, "R2", wbDestData, 8'hC3);
  endtask

  task automatic testStoreLoad();
    slot(1, 3'd1, 8'h20, 8'h11, 3'd4, 8'h99, 8'h00);
    check(wbWrEn == 1'b0, "R3", wbWrEn, 0);
    check(!cWr && !cRd, "R3", {cWr, cRd}, 0);
    slot(1, 3'd2, 8'h20, 8'h00, 3'd2, 8'h99, 8'h00);
    check(wbDestData == 8'h11, "R4", wbDestData, 8'h11);
    check(wbDestIdx == 3'd2 && wbWrEn, "R4", wbDestIdx, 2);
    slot(1, 3'd1, 8'hFF, 8'hA5, 3'd1, 8'h00, 8'h00);
    slot(1, 3'd2, 8'hFF, 8'h00, 3'd1, 8'h00, 8'h00);
    check(wbDestData == 8'hA5, "R11", wbDestData, 8'hA5);
    slot(1, 3'd1, 8'h00, 8'h3C, 3'd1, 8'h00, 8'h00);
    slot(1, 3'd2, 8'h00, 8'h00, 3'd6, 8'h00, 8'h00);
    check(wbDestData == 8'h3C, "R11", wbDestData, 8'h3C);
  endtask

  task automatic testPortOut();
    slot(1, 3'd1, 8'h40, 8'h77, 3'd1, 8'h00, 8'h00);
    slot(1, 3'd3, 8'h40, 8'h99, 3'd5, 8'h00, 8'h00);
    check(cWr && !cRd, "R5", {cWr, cRd}, 2);
    check(cAddr == 8'h40, "R5", cAddr, 8'h40);
    check(cData == 8'h99, "R5", cData, 8'h99);
    check(wbWrEn == 1'b0, "R5", wbWrEn, 0);
    slot(1, 3'd2, 8'h40, 8'h00, 3'd3, 8'h00, 8'h00);
    check(wbDestData == 8'h77, "R9", wbDestData, 8'h77);
  endtask

  task automatic testPortIn();
    slot(1, 3'd4, 8'h80, 8'h55, 3'd5, 8'h12, 8'hE6);
    check(cRd && !cWr, "R6", {cWr, cRd}, 1);
    check(cAddr == 8'h80, "R6", cAddr, 8'h80);
    check(cData == 8'h00, "R10", cData, 0);
    check(wbDestData == 8'hE6 && wbDestIdx == 3'd5, "R6", wbDestData, 8'hE6);
  endtask

  task automatic testInvalid();
    slot(0, 3'd1, 8'h20, 8'hAA, 3'd4, 8'h00, 8'h00);
    check(!cWr && !cRd, "R7", {cWr, cRd}, 0);
    check(wbWrEn == 1'b0, "R7", wbWrEn, 0);
    slot(0, 3'd3, 8'h21, 8'hAA, 3'd4, 8'h00, 8'h00);
    check(!cWr && !cRd, "R7", {cWr, cRd}, 0);
    slot(1, 3'd2, 8'h20, 8'h00, 3'd4, 8'h00, 8'h00);
    check(wbDestData == 8'h11, "R7", wbDestData, 8'h11);
  endtask

  task automatic testIdxZero();
    slot(1, 3'd0, 8'h00, 8'h00, 3'd0, 8'h6B, 8'h00);
    check(wbWrEn == 1'b0, "R8", wbWrEn, 0);
    slot(1, 3'd2, 8'h20, 8'h00, 3'd0, 8'h00, 8'h00);
    check(wbWrEn == 1'b0, "R8", wbWrEn, 0);
    slot(1, 3'd4, 8'h01, 8'h00, 3'd0, 8'h00, 8'h42);
    check(wbWrEn == 1'b0, "R8", wbWrEn, 0);
    slot(1, 3'd4, 8'h01, 8'h00, 3'd1, 8'h00, 8'h42);
    check(wbWrEn == 1'b1, "R8", wbWrEn, 1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    testReset();
    testPass();
    testStoreLoad();
    testPortOut();
    testPortIn();
    testInvalid();
    testIdxZero();
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    vectors++;
    misses++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    finishRun();
  end
endmodule